// File: doc/BRIEF.md
# Dual-Ring Command Fetch Engine

The engine pulls 32-bit command words out of two circular rings in memory and delivers them, tagged as 2D or 3D work, to a downstream parser over a valid/ready stream. Software never hands words to the engine directly. It writes packets into a ring and then moves that ring's tail pointer forward. The engine advances the matching head pointer as it consumes words, fetching them through a burst read port into a 16-entry FIFO.

One ring is urgent and the other is background. At every burst decision the urgent ring wins if it holds work and is enabled. A control word in a ring can divert fetching to a batch buffer elsewhere in memory. A matching end word sends fetching back to the ring, which resumes just past the diverting word. Control words are consumed by the engine and never reach the output.

Words are decoded as they come back from memory, before they enter the FIFO. That way a redirect discards the rest of the burst that is already in flight. Each burst is treated as one packet: ring selection and enable gating happen only between bursts.

Top module: `cmd_fetch_engine`

## Requirements
- R1: After reset, `rd_req_o`, `cmd_valid_o`, `err_illegal_o` and `err_nest_o` are low, and both head outputs are zero.
- R2: A ring's words are fetched in order from address base+head, up to the word before the tail. The head wraps to 0 after size-1 and ends equal to the tail. No burst crosses the wrap point.
- R3: A burst length is 1 to 4 words. The request stays high with a stable address until acknowledged. A burst is issued only when at least 4 FIFO slots are free, so FIFO occupancy never exceeds 16.
- R4: When both rings are enabled and non-empty at a burst decision, the urgent ring is served first. A single burst never mixes rings.
- R5: In a ring, a control word (bits [31:29]=000, bits [28:27]=01) advances the head past itself and moves fetching to the batch address in its low 16 bits. The remaining words of that burst are discarded.
- R6: In a batch, a control word with bits [28:27]=10 ends the batch and discards the rest of the burst. Fetching then resumes from the ring head via normal arbitration.
- R7: A call word (op 01) inside a batch raises `err_nest_o` for one cycle and is otherwise ignored; the batch continues.
- R8: Words with bits [31:29]=011 are sent out with `cmd_3d_o`=1, and words with 010 with `cmd_3d_o`=0. The word itself is unmodified.
- R9: Any other class value, and any control op not valid in its context (an end word in a ring, op 00 or 11 anywhere), is dropped. Each such word raises `err_illegal_o` for one cycle. The ring head still advances past it.
- R10: A ring whose enable is low is not fetched and its head does not move. Enable is sampled only at burst decisions.
- R11: While `cmd_valid_o` is high and `cmd_ready_i` is low, the output word and tag hold. Output order equals fetch order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hp_en_i | input | 1 | Urgent ring fetch enable |
| hp_base_i | input | 16 | Urgent ring base word address |
| hp_size_i | input | 16 | Urgent ring size in words |
| hp_tail_i | input | 16 | Urgent ring tail (software-owned) |
| hp_head_o | output | 16 | Urgent ring head |
| lp_en_i | input | 1 | Background ring fetch enable |
| lp_base_i | input | 16 | Background ring base word address |
| lp_size_i | input | 16 | Background ring size in words |
| lp_tail_i | input | 16 | Background ring tail |
| lp_head_o | output | 16 | Background ring head |
| rd_req_o | output | 1 | Burst read request |
| rd_addr_o | output | 16 | Burst start word address |
| rd_len_o | output | 3 | Burst length in words (1 to 4) |
| rd_ack_i | input | 1 | Request accepted |
| rd_vld_i | input | 1 | Read data beat valid |
| rd_data_i | input | 32 | Read data beat |
| cmd_valid_o | output | 1 | Output word valid |
| cmd_ready_i | input | 1 | Parser ready |
| cmd_word_o | output | 32 | Command word |
| cmd_3d_o | output | 1 | 1 = 3D class, 0 = 2D class |
| err_illegal_o | output | 1 | One-cycle pulse per dropped illegal word |
| err_nest_o | output | 1 | One-cycle pulse per ignored nested call |

## Verification
The properties assume a well-behaved memory and software side. After each acknowledge, memory returns exactly `rd_len_o` beats, in order and with at most one request outstanding. Each ring has a size of at least 2, a tail below its size, and a tail that only moves forward without passing the head. The bench's memory responder acknowledges only a raised request and supplies exactly the requested beat count, sometimes with an idle gap. Tails are advanced by fewer than the ring size per round, and the buffer memory is written before the tail moves.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef enum logic [1:0] {SRC_HP, SRC_LP, SRC_BAT} src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA} st_e;
  localparam logic [2:0] CLS_CTRL = 3'b000;
  localparam logic [2:0] CLS_2D   = 3'b010;
  localparam logic [2:0] CLS_3D   = 3'b011;
  localparam logic [1:0] OP_CALL  = 2'b01;
  localparam logic [1:0] OP_RET   = 2'b10;
endpackage

// File: rtl/cfe_ring_ptr.sv
module cfe_ring_ptr #(
  parameter int AW = 16,
  parameter int BURST = 4,
  parameter int LW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] tail_i,
  input  logic          adv_i,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o,
  output logic          nonempty_o
);
  logic [AW-1:0] head_q, run;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) head_q <= '0;
    else if (adv_i) head_q <= (head_q + 1'b1 == size_i) ? '0 : head_q + 1'b1;

  // contiguous words up to tail or wrap point, whichever is first
  always_comb begin
    run        = (tail_i >= head_q) ? tail_i - head_q : size_i - head_q;
    len_o      = (run > AW'(BURST)) ? LW'(BURST) : run[LW-1:0];
    nonempty_o = head_q != tail_i;
    addr_o     = base_i + head_q;
    head_o     = head_q;
  end
endmodule

// File: rtl/cfe_fifo.sv
module cfe_fifo #(
  parameter int W = 33,
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  localparam int PW = $clog2(DEPTH);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign valid_o = cnt_q != '0;
  assign pop     = valid_o && ready_i;
  assign rdata_o = mem[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i)
    if (push_i) mem[wp_q] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop)    rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop);
    end
endmodule

// File: rtl/cfe_fetch_ctl.sv
module cfe_fetch_ctl
  import cfe_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  parameter int LW = 3,
  parameter int CW = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          en_i,
  input  logic [1:0]          nonempty_i,
  input  logic [1:0][AW-1:0]  ring_addr_i,
  input  logic [1:0][LW-1:0]  ring_len_i,
  input  logic [CW-1:0]       fifo_cnt_i,
  output logic [1:0]          adv_o,
  output logic                rd_req_o,
  output logic [AW-1:0]       rd_addr_o,
  output logic [LW-1:0]       rd_len_o,
  input  logic                rd_ack_i,
  input  logic                rd_vld_i,
  input  logic [DW-1:0]       rd_data_i,
  output logic                push_o,
  output logic [DW:0]         push_data_o,
  output logic                err_illegal_o,
  output logic                err_nest_o
);
  st_e           st_q;
  src_e          src_q;
  logic          in_bat_q, disc_q, ill_q, nest_q;
  logic [LW-1:0] beats_q, len_q;
  logic [AW-1:0] addr_q, bat_q;
  logic [2:0]    cls;
  logic [1:0]    op;
  logic          take, is_cmd, is_call, is_ret, last, room;

  always_comb begin
    cls     = rd_data_i[DW-1 -: 3];
    op      = rd_data_i[DW-4 -: 2];
    take    = (st_q == ST_DATA) && rd_vld_i && !disc_q;
    last    = (st_q == ST_DATA) && rd_vld_i && (beats_q == LW'(1));
    is_cmd  = (cls == CLS_2D) || (cls == CLS_3D);
    is_call = (cls == CLS_CTRL) && (op == OP_CALL);
    is_ret  = (cls == CLS_CTRL) && (op == OP_RET);
    room    = fifo_cnt_i <= CW'(DEPTH - BURST);
    push_o      = take && is_cmd;
    push_data_o = {cls == CLS_3D, rd_data_i};
    adv_o[0]    = take && (src_q == SRC_HP);
    adv_o[1]    = take && (src_q == SRC_LP);
    rd_req_o    = st_q == ST_REQ;
    rd_addr_o   = addr_q;
    rd_len_o    = len_q;
    err_illegal_o = ill_q;
    err_nest_o    = nest_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      src_q    <= SRC_HP;
      in_bat_q <= 1'b0;
      disc_q   <= 1'b0;
      beats_q  <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      bat_q    <= '0;
      ill_q    <= 1'b0;
      nest_q   <= 1'b0;
    end else begin
      ill_q  <= take && !is_cmd && !is_call && !(is_ret && src_q == SRC_BAT);
      nest_q <= take && is_call && (src_q == SRC_BAT);
      unique case (st_q)
        ST_IDLE: if (room) begin
          // one burst = one packet: arbitration and enables sampled here only
          if (in_bat_q) begin
            src_q <= SRC_BAT; addr_q <= bat_q; len_q <= LW'(BURST); st_q <= ST_REQ;
          end else if (en_i[0] && nonempty_i[0]) begin
            src_q <= SRC_HP; addr_q <= ring_addr_i[0]; len_q <= ring_len_i[0]; st_q <= ST_REQ;
          end else if (en_i[1] && nonempty_i[1]) begin
            src_q <= SRC_LP; addr_q <= ring_addr_i[1]; len_q <= ring_len_i[1]; st_q <= ST_REQ;
          end
        end
        ST_REQ: if (rd_ack_i) begin
          st_q    <= ST_DATA;
          beats_q <= len_q;
        end
        ST_DATA: if (rd_vld_i) begin
          beats_q <= beats_q - 1'b1;
          if (take) begin
            if (src_q == SRC_BAT) begin
              bat_q <= bat_q + 1'b1;
              if (is_ret) begin in_bat_q <= 1'b0; disc_q <= 1'b1; end
            end else if (is_call) begin
              bat_q <= rd_data_i[AW-1:0]; in_bat_q <= 1'b1; disc_q <= 1'b1;
            end
          end
          if (last) begin st_q <= ST_IDLE; disc_q <= 1'b0; end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
endmodule

// File: rtl/cmd_fetch_engine.sv
module cmd_fetch_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  localparam int LW = $clog2(BURST + 1),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hp_en_i,
  input  logic [AW-1:0] hp_base_i,
  input  logic [AW-1:0] hp_size_i,
  input  logic [AW-1:0] hp_tail_i,
  output logic [AW-1:0] hp_head_o,
  input  logic          lp_en_i,
  input  logic [AW-1:0] lp_base_i,
  input  logic [AW-1:0] lp_size_i,
  input  logic [AW-1:0] lp_tail_i,
  output logic [AW-1:0] lp_head_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [LW-1:0] rd_len_o,
  input  logic          rd_ack_i,
  input  logic          rd_vld_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          cmd_valid_o,
  input  logic          cmd_ready_i,
  output logic [DW-1:0] cmd_word_o,
  output logic          cmd_3d_o,
  output logic          err_illegal_o,
  output logic          err_nest_o
);
  logic [1:0][AW-1:0] base_a, size_a, tail_a, head_a, addr_a;
  logic [1:0][LW-1:0] len_a;
  logic [1:0]         ne_a, adv_a, en_a;
  logic               push;
  logic [DW:0]        push_data, fifo_out;
  logic [CW-1:0]      fifo_cnt;

  assign base_a = {lp_base_i, hp_base_i};
  assign size_a = {lp_size_i, hp_size_i};
  assign tail_a = {lp_tail_i, hp_tail_i};
  assign en_a   = {lp_en_i, hp_en_i};
  assign hp_head_o = head_a[0];
  assign lp_head_o = head_a[1];

  for (genvar g = 0; g < 2; g++) begin : g_ring
    cfe_ring_ptr #(.AW(AW), .BURST(BURST), .LW(LW)) u_ptr (
      .clk_i, .rst_ni,
      .base_i(base_a[g]), .size_i(size_a[g]), .tail_i(tail_a[g]),
      .adv_i(adv_a[g]), .head_o(head_a[g]), .addr_o(addr_a[g]),
      .len_o(len_a[g]), .nonempty_o(ne_a[g])
    );
  end

  cfe_fetch_ctl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BURST(BURST), .LW(LW), .CW(CW)) u_ctl (
    .clk_i, .rst_ni,
    .en_i(en_a), .nonempty_i(ne_a), .ring_addr_i(addr_a), .ring_len_i(len_a),
    .fifo_cnt_i(fifo_cnt), .adv_o(adv_a),
    .rd_req_o, .rd_addr_o, .rd_len_o, .rd_ack_i, .rd_vld_i, .rd_data_i,
    .push_o(push), .push_data_o(push_data),
    .err_illegal_o, .err_nest_o
  );

  cfe_fifo #(.W(DW + 1), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .wdata_i(push_data), .ready_i(cmd_ready_i),
    .valid_o(cmd_valid_o), .rdata_o(fifo_out), .count_o(fifo_cnt)
  );

  assign cmd_3d_o   = fifo_out[DW];
  assign cmd_word_o = fifo_out[DW-1:0];
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 16,
  parameter int BURST = 4,
  parameter int LW = 3,
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_req_o,
  input logic          rd_ack_i,
  input logic [AW-1:0] rd_addr_o,
  input logic [LW-1:0] rd_len_o,
  input logic          cmd_valid_o,
  input logic          cmd_ready_i,
  input logic [DW-1:0] cmd_word_o,
  input logic          cmd_3d_o,
  input logic [CW-1:0] fifo_cnt,
  input logic [AW-1:0] hp_head_o,
  input logic [AW-1:0] lp_head_o
);
  // R3
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_len_o != '0) && (rd_len_o <= LW'(BURST)));
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_len_o));
  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));
  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_word_o) && $stable(cmd_3d_o));
  // R8
  out_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_word_o[DW-1 -: 2] == 2'b01) && (cmd_3d_o == cmd_word_o[DW-3]));
  // R2
  hp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hp_head_o) |-> (hp_head_o == $past(hp_head_o) + 1'b1) || (hp_head_o == '0));
  // R2
  lp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lp_head_o) |-> (lp_head_o == $past(lp_head_o) + 1'b1) || (lp_head_o == '0));
endmodule

bind cmd_fetch_engine cfe_checker #(
  .AW(AW), .DW(DW), .DEPTH(DEPTH), .BURST(BURST), .LW(LW), .CW(CW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_addr_o(rd_addr_o), .rd_len_o(rd_len_o),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_word_o(cmd_word_o),
  .cmd_3d_o(cmd_3d_o), .fifo_cnt(fifo_cnt), .hp_head_o(hp_head_o), .lp_head_o(lp_head_o)
);

// File: tb/cmd_fetch_engine_test.sv
`timescale 1ns/1ps
module cmd_fetch_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hp_en = 1'b0, lp_en = 1'b0;
  logic [15:0] rb [2];
  logic [15:0] rs [2];
  logic [15:0] tail [2];
  logic [15:0] hp_head, lp_head, rd_addr;
  logic [2:0]  rd_len;
  logic        rd_req, rd_ack = 1'b0, rd_vld = 1'b0;
  logic [31:0] rd_data = '0, cmd_word;
  logic        cmd_valid, cmd_ready = 1'b1, cmd_3d, err_ill, err_nest;
  logic [31:0] mem [256];
  logic [32:0] exp_q[$], got_q[$];
  int          nchk = 0, nerr = 0, ill_cnt = 0, nest_cnt = 0, cyc = 0;
  bit          bp = 1'b0, gaps = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  cmd_fetch_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .hp_en_i(hp_en), .hp_base_i(rb[0]), .hp_size_i(rs[0]), .hp_tail_i(tail[0]), .hp_head_o(hp_head),
    .lp_en_i(lp_en), .lp_base_i(rb[1]), .lp_size_i(rs[1]), .lp_tail_i(tail[1]), .lp_head_o(lp_head),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_len_o(rd_len), .rd_ack_i(rd_ack),
    .rd_vld_i(rd_vld), .rd_data_i(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_word_o(cmd_word), .cmd_3d_o(cmd_3d),
    .err_illegal_o(err_ill), .err_nest_o(err_nest)
  );

  task automatic chk(string req, bit ok, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(bit is3d, int id);
    return {is3d ? 3'b011 : 3'b010, 29'(id)};
  endfunction

  task automatic ring_put(int r, logic [31:0] w);
    mem[8'(rb[r] + tail[r])] = w;
    tail[r] = (tail[r] + 16'd1 == rs[r]) ? 16'd0 : tail[r] + 16'd1;
  endtask

  task automatic exp_add(logic [31:0] w);
    exp_q.push_back({w[29], w});
  endtask

  task automatic settle_compare(string req);
    repeat (150) @(posedge clk);
    @(negedge clk);
    chk(req, got_q.size() == exp_q.size(), got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      chk(req, got_q[i][31:0] == exp_q[i][31:0], got_q[i][31:0], exp_q[i][31:0]);
      chk("R8", got_q[i][32] == exp_q[i][32], got_q[i][32], exp_q[i][32]);
    end
    // R2: heads catch up with tails
    chk("R2", hp_head == tail[0], hp_head, tail[0]);
    chk("R2", lp_head == tail[1], lp_head, tail[1]);
    exp_q.delete();
    got_q.delete();
  endtask

  // memory responder: one outstanding burst, exact beat count
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req && rst_n) begin
        automatic logic [15:0] a = rd_addr;
        automatic int n = rd_len;
        // R3 and R2: legal length, no burst over a ring wrap
        chk("R3", n >= 1 && n <= 4, n, 4);
        for (int r = 0; r < 2; r++)
          if (a >= rb[r] && a < rb[r] + rs[r])
            chk("R2", a + n <= rb[r] + rs[r], a + n, rb[r] + rs[r]);
        rd_ack = 1'b1;
        @(posedge clk); #1 rd_ack = 1'b0;
        for (int i = 0; i < n; i++) begin
          if (gaps && i == 1) begin @(posedge clk); #1; end
          rd_vld = 1'b1;
          rd_data = mem[8'(a + 16'(i))];
          @(posedge clk); #1;
          rd_vld = 1'b0;
        end
      end
    end
  end

  // output collector, pulse counters, hold check
  initial begin
    logic pv, pr;
    logic [32:0] pw;
    pv = 1'b0; pr = 1'b1; pw = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (pv && !pr)
          chk("R11", cmd_valid && {cmd_3d, cmd_word} == pw, {cmd_3d, cmd_word}, pw);
        if (cmd_valid && cmd_ready) got_q.push_back({cmd_3d, cmd_word});
        if (err_ill) ill_cnt++;
        if (err_nest) nest_cnt++;
        pv = cmd_valid; pr = cmd_ready; pw = {cmd_3d, cmd_word};
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      cmd_ready = bp ? (cyc % 3 != 0) : 1'b1;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rb[0] = 16'h0000; rs[0] = 16'd8; tail[0] = '0;
    rb[1] = 16'h0010; rs[1] = 16'd6; tail[1] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1", !rd_req && !cmd_valid && !err_ill && !err_nest, {rd_req, cmd_valid, err_ill, err_nest}, 0);
    chk("R1", hp_head == 0 && lp_head == 0, {hp_head, lp_head}, 0);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 sweep on each ring alone, every fill level, several laps
    for (int r = 0; r < 2; r++) begin
      hp_en = (r == 0); lp_en = (r == 1);
      for (int lap = 0; lap < 3; lap++)
        for (int n = 1; n < rs[r]; n++) begin
          for (int k = 0; k < n; k++) begin
            automatic logic [31:0] w = mkw((k + lap) % 2 == 1, r * 4096 + lap * 256 + n * 16 + k);
            exp_add(w);
            ring_put(r, w);
          end
          settle_compare("R2");
        end
    end

    // R4: both rings loaded while disabled, enabled together
    hp_en = 1'b0; lp_en = 1'b0;
    @(posedge clk); #1;
    for (int k = 0; k < 3; k++) begin exp_add(mkw(1, 16'h700 + k)); ring_put(0, mkw(1, 16'h700 + k)); end
    for (int k = 0; k < 5; k++) ring_put(1, mkw(0, 16'h800 + k));
    for (int k = 0; k < 5; k++) exp_add(mkw(0, 16'h800 + k));
    // R10: disabled rings stay untouched
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R10", got_q.size() == 0 && !rd_req, got_q.size(), 0);
    chk("R10", hp_head == tail[0] - 16'd3 || hp_head + 16'd5 == tail[0], hp_head, tail[0]);
    @(posedge clk); #1;
    hp_en = 1'b1; lp_en = 1'b1;
    settle_compare("R4");

    // R5 R6 R7: batch call with nested call and return, gaps in data
    gaps = 1'b1;
    ill_cnt = 0; nest_cnt = 0;
    mem[8'h40] = mkw(0, 16'hC0);
    mem[8'h41] = mkw(1, 16'hC1);
    mem[8'h42] = 32'h0800_0099;      // nested call
    mem[8'h43] = mkw(1, 16'hC3);
    mem[8'h44] = 32'h1000_0000;      // batch end
    mem[8'h45] = mkw(0, 16'hBAD);    // discarded after end
    mem[8'h46] = mkw(0, 16'hBAD);
    mem[8'h47] = mkw(0, 16'hBAD);
    hp_en = 1'b0;
    ring_put(1, mkw(0, 16'hA0));
    ring_put(1, 32'h0800_0040);      // call into batch at 0x40
    ring_put(1, mkw(1, 16'hB0));
    exp_add(mkw(0, 16'hA0));
    exp_add(mkw(0, 16'hC0));
    exp_add(mkw(1, 16'hC1));
    exp_add(mkw(1, 16'hC3));
    exp_add(mkw(1, 16'hB0));
    settle_compare("R5");
    chk("R7", nest_cnt == 1, nest_cnt, 1);
    chk("R6", ill_cnt == 0, ill_cnt, 0);

    // R9: illegal classes and misplaced control ops
    ill_cnt = 0; nest_cnt = 0;
    ring_put(1, mkw(1, 16'hD0));
    ring_put(1, 32'hE000_0001);
    ring_put(1, 32'h1000_0000);      // end word in a ring
    ring_put(1, mkw(0, 16'hD1));
    ring_put(1, 32'h1800_0000);      // op 11
    exp_add(mkw(1, 16'hD0));
    exp_add(mkw(0, 16'hD1));
    settle_compare("R9");
    chk("R9", ill_cnt == 3, ill_cnt, 3);
    chk("R9", nest_cnt == 0, nest_cnt, 0);

    // R11: backpressure on the output
    gaps = 1'b0; bp = 1'b1;
    hp_en = 1'b1;
    for (int k = 0; k < 7; k++) begin exp_add(mkw(k % 2 == 0, 16'hE0 + k)); ring_put(0, mkw(k % 2 == 0, 16'hE0 + k)); end
    for (int k = 0; k < 5; k++) begin exp_add(mkw(k % 2 == 1, 16'hF0 + k)); ring_put(1, mkw(k % 2 == 1, 16'hF0 + k)); end
    settle_compare("R11");
    bp = 1'b0;

    done = 1'b1;
    finish_run();
  end
endmodule